// File: doc/BRIEF.md
# Transmit Timeslot Payload Processor

This block sits on the transmit payload path and handles one byte per timeslot. Each accepted byte arrives with its timeslot index, a frame-start flag and a 4-bit signaling nibble. The byte runs through a fixed chain of stages under global and per-timeslot control: zero code suppression, substitution, signaling insertion, bit inversion and test-pattern replacement. Separately, the raw input can be tapped out toward an external pattern checker. Each result appears one clock after the byte is accepted.

Per-timeslot settings live in an internal table that is written through a single write port. Each table entry holds three fields: a test flag, a signaling-insert flag and a 3-bit substitution code. A global substitution code overrides every entry's own code unless it is zero. An external generator supplies the pattern byte for replacement. An external loopback source supplies the loopback byte. A small internal sequencer produces the milliwatt tone pattern.

There are no explicit states. The only sequential elements are:
- the output register, loaded when in_valid is high;
- the table entries;
- the 3-bit milliwatt phase counter. Its transitions are "hold", "advance" (a milliwatt byte is emitted) and "restart" (frame start).

Top module: `tx_slot_proc`

## Requirements
- R1: When cfg_en is 0, out_byte equals the accepted in_byte with no change, whatever the other controls are. out_valid follows in_valid with one cycle of latency. tap_valid stays 0.
- R2: Zero code suppression applies only when cfg_en=1, cfg_t1_mode=1, cfg_zcs_en=1 and cfg_zcs_type=00. An all-zero byte then becomes 0x02. Types 01, 10 and 11, and E1 mode (cfg_t1_mode=0), leave the byte unchanged.
- R3: The effective substitution code is cfg_gsubst when that is non-zero, and otherwise table bits 2:0 of the byte's timeslot. Code 001 replaces the byte with cfg_trunk. Code 010 replaces it with the milliwatt byte. Code 011 replaces it with lpbk_byte. Codes 000 and 100 to 111 leave it unchanged. Substitution is applied after zero code suppression.
- R4: The milliwatt byte cycles through 1E,0B,0B,1E,9E,8B,8B,9E and advances once per byte that uses code 010 while enabled. A valid byte with in_frame_start=1 restarts the cycle, so that byte takes 1E (if it is substituted).
- R5: When table bit 3 of the timeslot is 1 and cfg_en=1, bits 3:0 of the byte after substitution are replaced by in_sig.
- R6: Inversions are applied after signaling insertion, each as an independent XOR. cfg_inv_msb flips bit 7. cfg_inv_even flips bits 0,2,4,6. cfg_inv_odd flips bits 1,3,5,7. Setting msb and odd together leaves bit 7 unchanged.
- R7: With cfg_en=1, cfg_test_en=1 and cfg_test_dir=1, replacement is the last stage, and cfg_test_mode selects its scope:
  - mode 00 replaces every byte with gen_byte and ignores the test flag;
  - mode 01 replaces the whole byte only on timeslots whose table bit 4 is 1;
  - mode 10 replaces only bits 7:1 on such timeslots, and bit 0 passes through;
  - mode 11 has no effect.
- R8: With cfg_en=1, cfg_test_en=1 and cfg_test_dir=0, the raw in_byte is tapped under the same mode rules as R7. tap_valid is 1 for each tapped byte, in the same cycle as out_valid. tap_byte is in_byte, with bit 0 forced to 0 in mode 10. tap_byte is 0 when no tap occurs. The tap never alters out_byte.
- R9: A table write (tbl_we=1) stores tbl_data into entry tbl_addr. A byte accepted in the same cycle as the write uses the old entry contents; bytes accepted later use the new contents.
- R10: After reset, out_valid, tap_valid, out_byte and tap_byte are 0, every table entry is 0 and the milliwatt phase is at its first byte.
- R11: With cfg_test_en=0, neither tapping nor replacement occurs in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Master enable for all processing |
| cfg_t1_mode | input | 1 | 1 = 24-channel mode, 0 = 32-timeslot mode |
| cfg_zcs_en | input | 1 | Zero code suppression enable |
| cfg_zcs_type | input | 2 | Suppression type; only 00 acts |
| cfg_gsubst | input | 3 | Global substitution code, 000 = use per-slot codes |
| cfg_trunk | input | 8 | Trunk code byte |
| cfg_inv_msb | input | 1 | Invert bit 7 |
| cfg_inv_even | input | 1 | Invert bits 0,2,4,6 |
| cfg_inv_odd | input | 1 | Invert bits 1,3,5,7 |
| cfg_test_en | input | 1 | Test path enable |
| cfg_test_dir | input | 1 | 0 = tap to checker, 1 = replace with generator |
| cfg_test_mode | input | 2 | 00 unframed, 01 8-bit, 10 7-bit, 11 off |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table entry to write |
| tbl_data | input | 5 | {test flag, signaling flag, subst code[2:0]} |
| in_valid | input | 1 | Input byte valid |
| in_slot | input | 5 | Timeslot index of the input byte |
| in_frame_start | input | 1 | Byte is the first of a frame |
| in_byte | input | 8 | Payload byte |
| in_sig | input | 4 | Signaling nibble |
| gen_byte | input | 8 | Pattern byte from external generator |
| lpbk_byte | input | 8 | Payload loopback byte |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Processed byte |
| tap_valid | output | 1 | Tapped byte valid |
| tap_byte | output | 8 | Byte toward the external checker |

## Verification
The assertions assume the following about the inputs: configuration inputs are held steady while a byte is accepted, in_slot stays below the table depth, and the generator byte is sampled in the same cycle as its payload byte. The stimulus changes configuration only between bytes, at the falling clock edge. It uses timeslot indices 0 to 31 only, and it presents gen_byte and lpbk_byte alongside each payload byte. A behavioural model in the bench recomputes every output from these rules, with its own copy of the table and of the milliwatt phase.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    typedef enum logic [1:0] {
        TM_UNFRAMED = 2'b00,
        TM_BYTE8    = 2'b01,
        TM_BIT7     = 2'b10,
        TM_OFF      = 2'b11
    } test_mode_e;

    localparam logic [2:0] SB_NONE  = 3'd0;
    localparam logic [2:0] SB_TRUNK = 3'd1;
    localparam logic [2:0] SB_MWATT = 3'd2;
    localparam logic [2:0] SB_LOOP  = 3'd3;

    typedef struct packed {
        logic       test;
        logic       sig;
        logic [2:0] subst;
    } slot_cfg_t;
endpackage

// File: rtl/tsp_cfg_table.sv
module tsp_cfg_table
    import tsp_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SW-1:0]   waddr,
    input  slot_cfg_t       wdata,
    input  logic [SW-1:0]   raddr,
    output slot_cfg_t       rdata
);
    slot_cfg_t entry_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (we && (waddr == SW'(g)))
                entry_q[g] <= wdata;
        end
    end

    assign rdata = entry_q[raddr];
endmodule

// File: rtl/tsp_mwatt.sv
module tsp_mwatt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       advance,
    output logic [7:0] mw_byte
);
    logic [2:0] phase_q;
    logic [2:0] phase_cur;

    assign phase_cur = restart ? 3'd0 : phase_q;
    // High bit follows phase[2]; low pattern alternates 1E,0B,0B,1E
    assign mw_byte = {phase_cur[2],
                      (phase_cur[1:0] == 2'd0 || phase_cur[1:0] == 2'd3) ? 7'h1E : 7'h0B};

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 3'd0;
        else if (advance)
            phase_q <= phase_cur + 3'd1;
        else if (restart)
            phase_q <= 3'd0;
    end

    // R4
    mw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/tsp_dpath.sv
module tsp_dpath
    import tsp_pkg::*;
(
    input  logic       en,
    input  logic       t1_mode,
    input  logic       zcs_en,
    input  logic [1:0] zcs_type,
    input  logic [2:0] gsubst,
    input  logic [7:0] trunk,
    input  logic       inv_msb,
    input  logic       inv_even,
    input  logic       inv_odd,
    input  logic       test_en,
    input  logic       test_dir,
    input  logic [1:0] test_mode,
    input  slot_cfg_t  slot_cfg,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic [3:0] in_sig,
    input  logic [7:0] gen_byte,
    input  logic [7:0] lpbk_byte,
    input  logic [7:0] mw_byte,
    output logic       mw_advance,
    output logic [7:0] nxt_byte,
    output logic       nxt_tap_v,
    output logic [7:0] nxt_tap
);
    logic [2:0] eff_sub;
    logic       hit;
    logic       test_act;
    logic [7:0] mask;
    logic [7:0] x;

    assign eff_sub = (gsubst != SB_NONE) ? gsubst : slot_cfg.subst;

    always_comb begin
        unique case (test_mode_e'(test_mode))
            TM_UNFRAMED: begin hit = 1'b1;          mask = 8'hFF; end
            TM_BYTE8:    begin hit = slot_cfg.test; mask = 8'hFF; end
            TM_BIT7:     begin hit = slot_cfg.test; mask = 8'hFE; end
            default:     begin hit = 1'b0;          mask = 8'hFF; end
        endcase
    end

    assign test_act = en && test_en && hit;

    always_comb begin
        x = in_byte;
        if (en) begin
            if (t1_mode && zcs_en && zcs_type == 2'b00 && x == 8'h00)
                x = 8'h02;
            unique case (eff_sub)
                SB_TRUNK: x = trunk;
                SB_MWATT: x = mw_byte;
                SB_LOOP:  x = lpbk_byte;
                default:  x = x;
            endcase
            if (slot_cfg.sig)
                x[3:0] = in_sig;
            if (inv_msb)  x = x ^ 8'h80;
            if (inv_even) x = x ^ 8'h55;
            if (inv_odd)  x = x ^ 8'hAA;
            if (test_act && test_dir)
                x = (x & ~mask) | (gen_byte & mask);
        end
        nxt_byte = x;
    end

    assign nxt_tap_v  = in_valid && test_act && !test_dir;
    assign nxt_tap    = nxt_tap_v ? (in_byte & mask) : 8'h00;
    assign mw_advance = in_valid && en && (eff_sub == SB_MWATT);
endmodule

// File: rtl/tx_slot_proc.sv
module tx_slot_proc
    import tsp_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          cfg_t1_mode,
    input  logic          cfg_zcs_en,
    input  logic [1:0]    cfg_zcs_type,
    input  logic [2:0]    cfg_gsubst,
    input  logic [7:0]    cfg_trunk,
    input  logic          cfg_inv_msb,
    input  logic          cfg_inv_even,
    input  logic          cfg_inv_odd,
    input  logic          cfg_test_en,
    input  logic          cfg_test_dir,
    input  logic [1:0]    cfg_test_mode,
    input  logic          tbl_we,
    input  logic [SW-1:0] tbl_addr,
    input  logic [4:0]    tbl_data,
    input  logic          in_valid,
    input  logic [SW-1:0] in_slot,
    input  logic          in_frame_start,
    input  logic [7:0]    in_byte,
    input  logic [3:0]    in_sig,
    input  logic [7:0]    gen_byte,
    input  logic [7:0]    lpbk_byte,
    output logic          out_valid,
    output logic [7:0]    out_byte,
    output logic          tap_valid,
    output logic [7:0]    tap_byte
);
    slot_cfg_t  slot_cfg;
    logic [7:0] mw_byte;
    logic       mw_advance;
    logic [7:0] nxt_byte;
    logic       nxt_tap_v;
    logic [7:0] nxt_tap;

    tsp_cfg_table #(.NSLOT(NSLOT)) table_i (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
        .wdata(slot_cfg_t'(tbl_data)), .raddr(in_slot), .rdata(slot_cfg)
    );

    tsp_mwatt mwatt_i (
        .clk(clk), .rst_n(rst_n), .restart(in_valid && in_frame_start),
        .advance(mw_advance), .mw_byte(mw_byte)
    );

    tsp_dpath dpath_i (
        .en(cfg_en), .t1_mode(cfg_t1_mode), .zcs_en(cfg_zcs_en),
        .zcs_type(cfg_zcs_type), .gsubst(cfg_gsubst), .trunk(cfg_trunk),
        .inv_msb(cfg_inv_msb), .inv_even(cfg_inv_even), .inv_odd(cfg_inv_odd),
        .test_en(cfg_test_en), .test_dir(cfg_test_dir), .test_mode(cfg_test_mode),
        .slot_cfg(slot_cfg), .in_valid(in_valid), .in_byte(in_byte),
        .in_sig(in_sig), .gen_byte(gen_byte), .lpbk_byte(lpbk_byte),
        .mw_byte(mw_byte), .mw_advance(mw_advance), .nxt_byte(nxt_byte),
        .nxt_tap_v(nxt_tap_v), .nxt_tap(nxt_tap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= 8'h00;
            tap_valid <= 1'b0;
            tap_byte  <= 8'h00;
        end else begin
            out_valid <= in_valid;
            tap_valid <= nxt_tap_v;
            tap_byte  <= nxt_tap;
            if (in_valid)
                out_byte <= nxt_byte;
        end
    end

    // R1
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_en) |=> (out_valid && !tap_valid && out_byte == $past(in_byte)));

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    unframed_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_en && cfg_test_en && cfg_test_dir && cfg_test_mode == 2'b00)
        |=> (out_byte == $past(gen_byte)));

    // R8
    unframed_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_en && cfg_test_en && !cfg_test_dir && cfg_test_mode == 2'b00)
        |=> (tap_valid && tap_byte == $past(in_byte)));

    // R11
    no_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_test_en |=> !tap_valid);
endmodule

// File: tb/tx_slot_proc_tb_top.sv
module tx_slot_proc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 0, cfg_t1_mode = 0, cfg_zcs_en = 0;
    logic [1:0] cfg_zcs_type = 0;
    logic [2:0] cfg_gsubst = 0;
    logic [7:0] cfg_trunk = 8'hD5;
    logic       cfg_inv_msb = 0, cfg_inv_even = 0, cfg_inv_odd = 0;
    logic       cfg_test_en = 0, cfg_test_dir = 0;
    logic [1:0] cfg_test_mode = 0;
    logic       tbl_we = 0;
    logic [4:0] tbl_addr = 0;
    logic [4:0] tbl_data = 0;
    logic       in_valid = 0;
    logic [4:0] in_slot = 0;
    logic       in_frame_start = 0;
    logic [7:0] in_byte = 0;
    logic [3:0] in_sig = 0;
    logic [7:0] gen_byte = 0;
    logic [7:0] lpbk_byte = 0;
    logic       out_valid, tap_valid;
    logic [7:0] out_byte, tap_byte;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int model_tbl [32];
    int model_mw = 0;

    always #2.5 clk = ~clk;

    tx_slot_proc dut_i (.*);

    function automatic int mw_at(int k);
        case (k)
            0: return 'h1E; 1: return 'h0B; 2: return 'h0B; 3: return 'h1E;
            4: return 'h9E; 5: return 'h8B; 6: return 'h8B; default: return 'h9E;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one byte (with optional table write) and compare after the edge
    task automatic put(string req, int slot, int b, int sig = 0, bit fs = 0,
                       int gen = 'hC3, int lb = 'h3C,
                       bit we = 0, int wa = 0, int wd = 0);
        int ent, code, r, tv, tb, m_lo, hit;
        ent = model_tbl[slot];
        r = b; tv = 0; tb = 0;
        if (fs) model_mw = 0;
        if (cfg_en) begin
            if (cfg_t1_mode && cfg_zcs_en && cfg_zcs_type == 0 && r == 0) r = 2;
            code = (cfg_gsubst != 0) ? cfg_gsubst : (ent & 7);
            if (code == 1) r = cfg_trunk;
            else if (code == 2) begin r = mw_at(model_mw); model_mw = (model_mw + 1) % 8; end
            else if (code == 3) r = lb;
            if ((ent >> 3) & 1) r = (r & 'hF0) | sig;
            for (int i = 0; i < 8; i++) begin
                if ((i == 7 && cfg_inv_msb) ^ (i % 2 == 0 && cfg_inv_even) ^ (i % 2 == 1 && cfg_inv_odd))
                    r = r ^ (1 << i);
            end
            hit = (cfg_test_mode == 0) ? 1 : (cfg_test_mode == 3) ? 0 : ((ent >> 4) & 1);
            m_lo = (cfg_test_mode == 2) ? 1 : 0;
            if (cfg_test_en && hit) begin
                if (cfg_test_dir) r = m_lo ? ((gen & 'hFE) | (r & 1)) : gen;
                else begin tv = 1; tb = m_lo ? (b & 'hFE) : b; end
            end
        end
        if (we) model_tbl[wa] = wd;
        in_valid = 1; in_slot = 5'(slot); in_byte = 8'(b); in_sig = 4'(sig);
        in_frame_start = fs; gen_byte = 8'(gen); lpbk_byte = 8'(lb);
        tbl_we = we; tbl_addr = 5'(wa); tbl_data = 5'(wd);
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; tbl_we = 0; in_frame_start = 0;
        check(req, out_valid, 1);
        check(req, out_byte, r);
        check(req, tap_valid, tv);
        check(req, tap_byte, tb);
    endtask

    task automatic wr(int a, int d);
        put("R9", 31, 'h00, 0, 0, 'hC3, 'h3C, 1, a, d);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model_tbl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check("R10", out_valid, 0);
        check("R10", tap_valid, 0);
        check("R10", out_byte, 0);
        check("R10", tap_byte, 0);

        // R1 disabled: everything else on
        cfg_gsubst = 1; cfg_inv_msb = 1; cfg_inv_even = 1;
        cfg_test_en = 1; cfg_test_dir = 1; cfg_test_mode = 0;
        put("R1", 3, 'h5A);
        cfg_test_dir = 0;
        put("R1", 4, 'hA7);
        @(negedge clk);
        check("R1", out_valid, 0);
        cfg_gsubst = 0; cfg_inv_msb = 0; cfg_inv_even = 0; cfg_test_en = 0;
        cfg_en = 1;

        // R10 empty table: plain pass-through
        put("R10", 9, 'h47);

        // R9 write slot 5 to trunk; same-cycle byte uses old entry
        put("R9", 5, 'h11, 0, 0, 'hC3, 'h3C, 1, 5, 1);
        put("R9", 5, 'h11);

        // R3 global overrides, per-slot codes
        wr(6, 3);
        wr(10, 5);
        put("R3", 6, 'h22, 0, 0, 'hC3, 'h99);
        put("R3", 10, 'h23);
        cfg_gsubst = 1;
        put("R3", 6, 'h24);
        cfg_gsubst = 6;
        put("R3", 5, 'h25);
        cfg_gsubst = 0;

        // R4 milliwatt sequence with frame restart
        wr(7, 2);
        for (int k = 0; k < 10; k++) put("R4", 7, k);
        put("R4", 9, 'h31, 0, 1);
        put("R4", 7, 'h32);
        put("R4", 7, 'h33, 0, 1);
        put("R4", 7, 'h34);

        // R2 zero code suppression
        cfg_t1_mode = 1; cfg_zcs_en = 1;
        put("R2", 0, 'h00);
        put("R2", 0, 'h40);
        cfg_zcs_type = 1;
        put("R2", 0, 'h00);
        cfg_zcs_type = 0; cfg_t1_mode = 0;
        put("R2", 0, 'h00);
        cfg_t1_mode = 1;
        wr(11, 1);
        put("R3", 11, 'h00);

        // R5 signaling insertion over trunk and over suppressed zero
        wr(8, 'h09);
        put("R5", 8, 'h66, 'hA);
        wr(12, 'h08);
        put("R5", 12, 'h00, 0);
        put("R5", 12, 'h7F, 5);
        cfg_t1_mode = 0; cfg_zcs_en = 0;

        // R6 inversions
        cfg_inv_msb = 1;
        put("R6", 0, 'h0F);
        cfg_inv_odd = 1;
        put("R6", 0, 'h0F);
        cfg_inv_msb = 0; cfg_inv_even = 1;
        put("R6", 0, 'h3C);
        put("R6", 8, 'h3C, 3);
        cfg_inv_odd = 0; cfg_inv_even = 0;

        // R7 replacement modes
        wr(13, 'h10);
        cfg_test_en = 1; cfg_test_dir = 1;
        for (int m = 0; m < 4; m++) begin
            cfg_test_mode = 2'(m);
            put("R7", 13, 'h81, 0, 0, 'h5A);
            put("R7", 14, 'h81, 0, 0, 'h5B);
            put("R7", 13, 'h00, 0, 0, 'hA5);
        end
        cfg_inv_msb = 1; cfg_test_mode = 2;
        put("R7", 13, 'h00, 0, 0, 'h33);
        cfg_inv_msb = 0;

        // R8 tap modes
        cfg_test_dir = 0;
        for (int m = 0; m < 4; m++) begin
            cfg_test_mode = 2'(m);
            put("R8", 13, 'h5B);
            put("R8", 14, 'hE7);
        end
        cfg_test_mode = 0;
        put("R8", 5, 'h99);

        // R11 test disabled
        cfg_test_en = 0;
        for (int m = 0; m < 3; m++) begin
            cfg_test_mode = 2'(m);
            cfg_test_dir = 1;
            put("R11", 13, 'h12, 0, 0, 'hEE);
            cfg_test_dir = 0;
            put("R11", 13, 'h13);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule